// File: doc/BRIEF.md
# Four-Lane Deskew and Word Alignment Buffer

The block takes several source-synchronous serial lanes and merges them into one word-aligned stream in a single read clock domain. Each lane delivers a 2-bit symbol on every rising edge of its own forwarded clock. The phase and jitter of each lane clock are independent of the others. Every lane writes into its own small elastic buffer in its own clock domain. A common read clock drains all the buffers. This clock has the same average frequency as the lanes.

Each buffer starts draining once it is half full. A repeating frame marker is present on every lane. A detector per lane looks for that marker in the last four symbols read. An alignment controller compares the cycles in which the markers arrive. It freezes the read pointer of any lane whose marker came earlier than the latest lane's marker, for one read cycle per slip. This repeats until all markers come out in the same read cycle. After three coincident marker periods the block raises an aligned flag. While the flag is high, the combined word is presented on the output.

Top module: `lane_deskew`

## Requirements
- R1: During and directly after reset, `aligned` is 0, `word_out` is 0, every slip count is 0 and every error bit is 0.
- R2: Each lane's symbols leave its buffer in the order they were written, with none lost or repeated while the buffer neither fills nor empties and the lane is not slipped.
- R3: A marker is recognised when a lane's last four read symbols, oldest in bits 7:6 and newest in bits 1:0, equal the `MARKER` parameter (default 8'hB4).
- R4: A marker period is closed when the last of the lanes delivers its marker inside a window of `WIN` read cycles. If at that point the lanes did not all deliver it together, and the block is not aligned, each lane whose marker came earlier has its read pointer frozen for exactly one read cycle. The slip count of that lane then goes up by one, saturating.
- R5: After a slip decision, further slip decisions are ignored for the next 4 read cycles. No lane's slip count changes twice within 5 read cycles.
- R6: `aligned` rises after 3 consecutive marker periods in which all lanes deliver their markers in the same read cycle. While `aligned` is high, no slips are made.
- R7: One mismatched marker period leaves `aligned` high. Two consecutive mismatched periods clear it, and then alignment restarts. A mismatched period is one where the markers are staggered, or one where the window expires with a lane missing.
- R8: `word_out` is registered one read cycle after the buffer outputs. It equals {lane3, lane2, lane1, lane0}, with lane 0 in bits 1:0, when `aligned` was high in the previous cycle, and 0 otherwise.
- R9: A buffer that has started draining and is empty when it must be read sets its lane's sticky `err_underflow` bit. That bit stays set until reset.
- R10: A write into a full buffer is dropped and sets its lane's sticky `err_overflow` bit. That bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rd | input | 1 | Common read clock |
| rst | input | 1 | Synchronous active-high reset, seen by every clock domain |
| lane_clk | input | LANES | Forwarded clock of each lane |
| lane_data | input | LANES*SYM_W | Lane symbols, lane n in bits n*SYM_W +: SYM_W |
| word_out | output | LANES*SYM_W | Combined aligned word, lane 0 in the low bits, zero while unaligned |
| aligned | output | 1 | Alignment achieved and held |
| slip_count | output | LANES*CNT_W | Saturating slip count per lane, lane n in bits n*CNT_W +: CNT_W |
| err_overflow | output | LANES | Sticky overflow bit per lane |
| err_underflow | output | LANES | Sticky underflow bit per lane |

## Verification
The output word trails the buffer outputs by one read cycle. Because of this, the bench gates every per-cycle word check by the `aligned` value it sampled on the previous falling edge. That gating applies both to zeroing and to the scoreboard comparison of lane 0 against the pushed symbol queue.

Marker periods are 16 read cycles long, and buffer crossing adds a few cycles of synchroniser delay. For that reason, flag transitions, slip counts and sticky errors are checked after waits bounded in whole frames, with timeouts. The slip spacing from R5 and the one-slip-per-lane response to a one-symbol skew are checked exactly, by watching the slip count ports on every cycle.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;
  // outcome of one marker period as seen by the alignment controller
  typedef enum logic [1:0] {
    PER_NONE = 2'd0,
    PER_COIN = 2'd1,
    PER_MISS = 2'd2
  } period_e;
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int W     = 2,
  parameter int DEPTH = 32
) (
  input  logic         wclk,
  input  logic         rst,
  input  logic [W-1:0] wdata,
  input  logic         rclk,
  input  logic         hold,
  output logic [W-1:0] rdata,
  output logic         rvalid,
  output logic         ovf,
  output logic         unf
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin, wgray, rg_s1, rg_s2;
  logic [AW:0]  rbin, rgray, wg_s1, wg_s2;
  logic [AW:0]  occ_w, occ_r, wbin_nx, rbin_nx;
  logic         full, empty, started, rd_en;

  function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  assign occ_w   = wbin - gray2bin(rg_s2);
  assign full    = (occ_w == (AW+1)'(DEPTH));
  assign wbin_nx = wbin + 1'b1;

  always_ff @(posedge wclk) begin
    if (!full) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      ovf   <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (full) begin
        ovf <= 1'b1;
      end else begin
        wbin  <= wbin_nx;
        wgray <= (wbin_nx >> 1) ^ wbin_nx;
      end
    end
  end

  // read domain
  assign occ_r   = gray2bin(wg_s2) - rbin;
  assign empty   = (occ_r == '0);
  assign rd_en   = started && !hold && !empty;
  assign rbin_nx = rbin + 1'b1;

  always_ff @(posedge rclk) begin
    if (rd_en) rdata <= mem[rbin[AW-1:0]];
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      started <= 1'b0;
      rvalid  <= 1'b0;
      unf     <= 1'b0;
    end else begin
      wg_s1  <= wgray;
      wg_s2  <= wg_s1;
      rvalid <= rd_en;
      if (!started) begin
        if (occ_r >= (AW+1)'(DEPTH / 2)) started <= 1'b1;
      end else if (!hold && empty) begin
        unf <= 1'b1;
      end
      if (rd_en) begin
        rbin  <= rbin_nx;
        rgray <= (rbin_nx >> 1) ^ rbin_nx;
      end
    end
  end
endmodule

// File: rtl/marker_det.sv
module marker_det #(
  parameter int            W      = 2,
  parameter int            SW     = 8,
  parameter logic [SW-1:0] MARKER = 8'hB4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sym,
  input  logic         valid,
  output logic         hit
);
  logic [SW-1:0] hist, hist_nx;

  assign hist_nx = {hist[SW-W-1:0], sym};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      hit  <= 1'b0;
    end else begin
      hit <= valid && (hist_nx == MARKER);
      if (valid) hist <= hist_nx;
    end
  end
endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
  import lane_deskew_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WIN    = 8,
  parameter int GUARD  = 4,
  parameter int LOCK   = 3,
  parameter int UNLOCK = 2,
  parameter int CNT_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       mk,
  output logic [LANES-1:0]       hold,
  output logic                   aligned,
  output logic [LANES*CNT_W-1:0] slip_count
);
  localparam int WCW = $clog2(WIN) + 1;
  localparam int GW  = $clog2(GUARD + 1) + 1;
  localparam int LKW = $clog2(LOCK + 1) + 1;
  localparam int ULW = $clog2(UNLOCK + 1) + 1;

  logic [LANES-1:0] seen, all_seen;
  logic             win_act, slip_ok;
  logic [WCW-1:0]   win_cnt;
  logic [GW-1:0]    guard;
  logic [LKW-1:0]   match_cnt;
  logic [ULW-1:0]   miss_cnt;
  logic [CNT_W-1:0] cnt [LANES];
  period_e          per;

  assign all_seen = seen | mk;

  always_comb begin
    per = PER_NONE;
    if (!win_act) begin
      if (&mk) per = PER_COIN;
    end else if (&all_seen || win_cnt == WCW'(WIN - 1)) begin
      per = PER_MISS;
    end
  end

  assign slip_ok = win_act && (&all_seen) && !aligned && (guard == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= '0;
      win_act   <= 1'b0;
      win_cnt   <= '0;
      guard     <= '0;
      hold      <= '0;
      match_cnt <= '0;
      miss_cnt  <= '0;
      aligned   <= 1'b0;
    end else begin
      hold <= slip_ok ? seen : '0;
      if (slip_ok) guard <= GW'(GUARD);
      else if (guard != '0) guard <= guard - 1'b1;

      if (!win_act) begin
        if (|mk && !(&mk)) begin
          win_act <= 1'b1;
          seen    <= mk;
          win_cnt <= '0;
        end
      end else if (per == PER_MISS) begin
        win_act <= 1'b0;
        seen    <= '0;
      end else begin
        seen    <= all_seen;
        win_cnt <= win_cnt + 1'b1;
      end

      case (per)
        PER_COIN: begin
          miss_cnt <= '0;
          if (!aligned) begin
            if (match_cnt == LKW'(LOCK - 1)) begin
              aligned   <= 1'b1;
              match_cnt <= '0;
            end else begin
              match_cnt <= match_cnt + 1'b1;
            end
          end
        end
        PER_MISS: begin
          match_cnt <= '0;
          if (aligned) begin
            if (miss_cnt == ULW'(UNLOCK - 1)) begin
              aligned  <= 1'b0;
              miss_cnt <= '0;
            end else begin
              miss_cnt <= miss_cnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt[g] <= '0;
      else if (slip_ok && seen[g] && cnt[g] != {CNT_W{1'b1}}) cnt[g] <= cnt[g] + 1'b1;
    end
    assign slip_count[g*CNT_W +: CNT_W] = cnt[g];
  end
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew #(
  parameter int                LANES          = 4,
  parameter int                SYM_W          = 2,
  parameter int                DEPTH          = 32,
  parameter int                MARK_W         = 8,
  parameter logic [MARK_W-1:0] MARKER         = 8'hB4,
  parameter int                WIN            = 8,
  parameter int                GUARD          = 4,
  parameter int                LOCK_PERIODS   = 3,
  parameter int                UNLOCK_PERIODS = 2,
  parameter int                CNT_W          = 8
) (
  input  logic                   clk_rd,
  input  logic                   rst,
  input  logic [LANES-1:0]       lane_clk,
  input  logic [LANES*SYM_W-1:0] lane_data,
  output logic [LANES*SYM_W-1:0] word_out,
  output logic                   aligned,
  output logic [LANES*CNT_W-1:0] slip_count,
  output logic [LANES-1:0]       err_overflow,
  output logic [LANES-1:0]       err_underflow
);
  logic [SYM_W-1:0]       lane_sym [LANES];
  logic [LANES-1:0]       lane_vld, mk, hold;
  logic [LANES*SYM_W-1:0] word_flat;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_fifo #(.W(SYM_W), .DEPTH(DEPTH)) u_fifo (
      .wclk   (lane_clk[g]),
      .rst    (rst),
      .wdata  (lane_data[g*SYM_W +: SYM_W]),
      .rclk   (clk_rd),
      .hold   (hold[g]),
      .rdata  (lane_sym[g]),
      .rvalid (lane_vld[g]),
      .ovf    (err_overflow[g]),
      .unf    (err_underflow[g])
    );
    marker_det #(.W(SYM_W), .SW(MARK_W), .MARKER(MARKER)) u_det (
      .clk   (clk_rd),
      .rst   (rst),
      .sym   (lane_sym[g]),
      .valid (lane_vld[g]),
      .hit   (mk[g])
    );
    assign word_flat[g*SYM_W +: SYM_W] = lane_sym[g];
  end

  align_ctrl #(
    .LANES(LANES), .WIN(WIN), .GUARD(GUARD), .LOCK(LOCK_PERIODS),
    .UNLOCK(UNLOCK_PERIODS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk        (clk_rd),
    .rst        (rst),
    .mk         (mk),
    .hold       (hold),
    .aligned    (aligned),
    .slip_count (slip_count)
  );

  always_ff @(posedge clk_rd) begin
    if (rst) word_out <= '0;
    else     word_out <= aligned ? word_flat : '0;
  end
endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
  parameter int LANES = 4,
  parameter int SYM_W = 2,
  parameter int CNT_W = 8,
  parameter int GUARD = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   aligned,
  input logic [LANES*SYM_W-1:0] word_out,
  input logic [LANES-1:0]       hold,
  input logic [LANES*CNT_W-1:0] slip_count,
  input logic [LANES-1:0]       err_overflow,
  input logic [LANES-1:0]       err_underflow
);
  logic [7:0] since_hold;

  always_ff @(posedge clk) begin
    if (rst) since_hold <= 8'hFF;
    else if (|hold) since_hold <= 8'd1;
    else if (since_hold != 8'hFF) since_hold <= since_hold + 8'd1;
  end

  p_slip_guard_r5: assert property (@(posedge clk) disable iff (rst)
    (|hold) |-> (since_hold >= 8'(GUARD + 1)));

  p_no_slip_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    aligned |-> (hold == '0));

  p_word_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !aligned |=> (word_out == '0));

  p_sticky_unf_r9: assert property (@(posedge clk) disable iff (rst)
    ((err_underflow & $past(err_underflow)) == $past(err_underflow)));

  p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (rst)
    ((err_overflow & $past(err_overflow)) == $past(err_overflow)));

  for (genvar g = 0; g < LANES; g++) begin : g_mono
    p_slip_step_r4: assert property (@(posedge clk) disable iff (rst)
      (slip_count[g*CNT_W +: CNT_W] == $past(slip_count[g*CNT_W +: CNT_W])) ||
      (slip_count[g*CNT_W +: CNT_W] == $past(slip_count[g*CNT_W +: CNT_W]) + 1'b1));
  end
endmodule

bind lane_deskew lane_deskew_chk #(
  .LANES(LANES), .SYM_W(SYM_W), .CNT_W(CNT_W), .GUARD(GUARD)
) u_chk (
  .clk           (clk_rd),
  .rst           (rst),
  .aligned       (aligned),
  .word_out      (word_out),
  .hold          (hold),
  .slip_count    (slip_count),
  .err_overflow  (err_overflow),
  .err_underflow (err_underflow)
);

// File: tb/lane_deskew_tb.sv
module lane_deskew_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         LANES      = 4;
  localparam int         CNT_W      = 8;
  localparam logic [7:0] PAT        = 8'hB4;

  logic       rclk = 1'b0;
  logic       rst  = 1'b1;
  wire  [3:0] lclk;
  wire  [7:0] ldat;
  logic [7:0] word_out;
  logic       aligned;
  logic [31:0] slip_count;
  logic [3:0] err_overflow, err_underflow;

  int   half [4];
  logic stop [4];
  int   ins_req [4];
  int   cor_req [4];
  logic [1:0] exp_q [$];

  int n_checks = 0, n_errors = 0, cyc = 0;
  logic eq_on = 1'b0;
  int   falls = 0;

  lane_deskew u_dut (
    .clk_rd(rclk), .rst(rst), .lane_clk(lclk), .lane_data(ldat),
    .word_out(word_out), .aligned(aligned), .slip_count(slip_count),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  always #(CLK_PERIOD / 2) rclk = ~rclk;

  // frame: 4 marker symbols (MSB pair first), then 12 payload symbols 0,1,2,3,...
  function automatic logic [1:0] sym(input int k);
    if (k < 4) return PAT[7-2*k -: 2];
    return 2'((k - 4) % 4);
  endfunction

  function automatic int doff(input int i);
    case (i) 0: return 0; 1: return 1; 2: return 3; default: return 2; endcase
  endfunction

  function automatic int phase(input int i);
    case (i) 0: return 1; 1: return 3; 2: return 6; default: return 8; endcase
  endfunction

  function automatic int slips(input int i);
    return int'(slip_count[i*CNT_W +: CNT_W]);
  endfunction

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      half[i] = CLK_PERIOD / 2; stop[i] = 1'b0; ins_req[i] = 0; cor_req[i] = 0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_ln
    logic       c = 1'b0;
    logic [1:0] d = 2'b00;
    assign lclk[g] = c;
    assign ldat[2*g +: 2] = d;

    task automatic send(input logic [1:0] s);
      d = s;
      if (g == 0) exp_q.push_back(s);
    endtask

    initial begin
      #(phase(g));
      forever begin
        #(half[g]);
        if (!stop[g]) c = ~c;
      end
    end

    initial begin
      int pos, ins_done, cor_done;
      logic [1:0] s;
      pos = doff(g); ins_done = 0; cor_done = 0;
      forever begin
        @(negedge c);
        if (pos == 4 && ins_req[g] > ins_done) begin
          ins_done++;
          send(sym(4));
        end else begin
          s = sym(pos);
          if (pos == 0 && cor_req[g] > cor_done) begin
            cor_done++;
            s = ~s;
          end
          send(s);
          pos = (pos + 1) % 16;
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    logic       al_prev, locked;
    logic [7:0] hist, tail;
    logic [1:0] e;
    int         prev_s [4];
    int         last_inc [4];
    al_prev = 1'b0; locked = 1'b0; hist = '0;
    for (int i = 0; i < 4; i++) begin prev_s[i] = 0; last_inc[i] = -100; end
    forever begin
      @(negedge rclk);
      cyc++;
      if (!rst) begin
        // R8: zero word while unaligned, fields equal when aligned
        if (!al_prev) chk("R8 word zero while unaligned", word_out == 8'h00, word_out, 0);
        else if (eq_on)
          chk("R8 lane fields coincide", word_out == {4{word_out[1:0]}}, word_out, {4{word_out[1:0]}});
        // R2: scoreboard on lane 0
        if (!al_prev) begin
          locked = 1'b0; hist = '0;
        end else if (locked) begin
          if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk("R2 lane0 symbol order", word_out[1:0] == e, word_out[1:0], e);
          end
        end else begin
          hist = {hist[5:0], word_out[1:0]};
          if (hist == PAT) begin
            tail = '0;
            while (exp_q.size() > 0 && tail != PAT) tail = {tail[5:0], exp_q.pop_front()};
            locked = (tail == PAT);
          end
        end
        if (!locked) while (exp_q.size() > 64) void'(exp_q.pop_front());
        // R5: slip spacing
        for (int i = 0; i < 4; i++) begin
          if (slips(i) != prev_s[i]) begin
            chk("R5 slip spacing", cyc - last_inc[i] >= 5, cyc - last_inc[i], 5);
            last_inc[i] = cyc;
            prev_s[i] = slips(i);
          end
        end
        if (al_prev && !aligned) falls++;
      end else begin
        while (exp_q.size() > 64) void'(exp_q.pop_front());
      end
      al_prev = aligned;
    end
  end

  task automatic wait_al(input logic v, input int maxc, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge rclk);
      if (aligned == v) begin ok = 1'b1; break; end
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end

  initial begin
    bit ok;
    int s0 [4];
    int f0;
    repeat (20) @(negedge rclk);
    // R1 reset state
    chk("R1 aligned in reset", aligned == 1'b0, aligned, 0);
    chk("R1 word in reset", word_out == 8'h00, word_out, 0);
    chk("R1 slip counts in reset", slip_count == 32'h0, slip_count, 0);
    chk("R1 error bits in reset", {err_overflow, err_underflow} == 8'h00, {err_overflow, err_underflow}, 0);
    rst = 1'b0;
    @(negedge rclk);
    chk("R1 aligned after reset", aligned == 1'b0, aligned, 0);
    chk("R1 slips after reset", slip_count == 32'h0, slip_count, 0);

    // R6 initial alignment from content skew
    wait_al(1'b1, 3000, ok);
    chk("R6 aligned reached", ok, ok, 1);
    repeat (20) @(negedge rclk);
    eq_on = 1'b1;
    for (int i = 0; i < 4; i++) s0[i] = slips(i);
    // R4: lane 2 leads by 3 symbols, lane 0 leads by none
    chk("R4 leading lane slipped more", slips(2) > slips(0), slips(2), slips(0) + 1);
    // R3: marker recognised on every lane, so slipping converged
    chk("R3 markers found on all lanes", aligned == 1'b1, aligned, 1);
    repeat (200) @(negedge rclk);
    for (int i = 0; i < 4; i++)
      chk("R6 no slip while aligned", slips(i) == s0[i], slips(i), s0[i]);

    // R7: one broken marker on lane 1 keeps alignment
    eq_on = 1'b0;
    f0 = falls;
    cor_req[1] = 1;
    repeat (150) @(negedge rclk);
    chk("R7 single miss keeps aligned", falls == f0 && aligned, falls - f0, 0);
    eq_on = 1'b1;
    repeat (40) @(negedge rclk);

    // R7/R4: one-symbol lag on lane 2 drops and restores alignment
    eq_on = 1'b0;
    for (int i = 0; i < 4; i++) s0[i] = slips(i);
    ins_req[2] = 1;
    wait_al(1'b0, 300, ok);
    chk("R7 two misses clear aligned", ok, ok, 1);
    wait_al(1'b1, 600, ok);
    chk("R7 realigned", ok, ok, 1);
    for (int i = 0; i < 4; i++)
      chk("R4 one slip per early lane", slips(i) == s0[i] + ((i == 2) ? 0 : 1), slips(i), s0[i] + ((i == 2) ? 0 : 1));
    repeat (20) @(negedge rclk);
    eq_on = 1'b1;
    repeat (100) @(negedge rclk);
    eq_on = 1'b0;
    chk("R9 no underflow in normal run", err_underflow == 4'h0, err_underflow, 0);
    chk("R10 no overflow in normal run", err_overflow == 4'h0, err_overflow, 0);

    // R9: starve lane 3
    stop[3] = 1'b1;
    repeat (100) @(negedge rclk);
    stop[3] = 1'b0;
    repeat (10) @(negedge rclk);
    chk("R9 underflow sticky on lane 3", err_underflow == 4'b1000, err_underflow, 8);
    chk("R10 no overflow after starve", err_overflow == 4'h0, err_overflow, 0);

    // R10: overdrive lane 1
    half[1] = 4;
    repeat (200) @(negedge rclk);
    half[1] = CLK_PERIOD / 2;
    repeat (20) @(negedge rclk);
    chk("R10 overflow sticky on lane 1", err_overflow == 4'b0010, err_overflow, 2);
    chk("R9 underflow still held", err_underflow[3] == 1'b1, err_underflow[3], 1);
    finish_up();
  end
endmodule